// File: doc/BRIEF.md
# SPI Byte FIFO Status and Interrupt Unit

This block sits between the register decoder of an SPI controller and its shift engine. It holds one byte FIFO for data the engine will send and one for data the engine has received. Software pushes outgoing bytes through a write port and pops incoming bytes through a read port. The shift engine pops outgoing bytes and pushes incoming ones on its own strobes. A packed status word reports how full each FIFO is.

Three event flags live in a status register. Two are watermark flags: one for the receive FIFO nearing full and one for the transmit FIFO nearing empty. The third is a transfer-done flag pulsed by the engine. Software clears a flag by writing a one to it. An enable register with the same bit layout selects which pending flags drive the single interrupt line. Two control bits flush each FIFO on its own, and each bit clears itself.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each FIFO holds 64 bytes and returns them in push order. The head of the transmit FIFO is shown on `eng_tx_data` and the head of the receive FIFO on `rx_rd_data`, and the new head appears in the cycle after the edge that pops.
- R2: `fifo_sta` carries the receive fill count in bits 6:0 and the transmit fill count in bits 22:16, each 7 bits wide so that 64 can be shown. Every other bit reads zero.
- R3: A push into a full FIFO is dropped and the count stays at 64. Fullness is judged before the edge, so a push with a pop on a full FIFO is also dropped.
- R4: While a FIFO is empty its head output reads zero. A pop from an empty FIFO leaves the count at zero.
- R5: A push and a pop at the same edge on a FIFO that is neither empty nor full leave the count unchanged and move the data along.
- R6: A control write with bit 8 set requests a transmit flush, and bit 9 a receive flush. The request shows on `flush_pend` (bit 0 transmit, bit 1 receive) for one cycle, then clears itself. At the next edge the FIFO empties and its count becomes zero, and any push or pop at that edge is ignored. The other FIFO is untouched.
- R7: Status bit 4 sets at the edge after the receive count reaches 48 or more.
- R8: Status bit 12 sets at the edge after the transmit count is 16 or less.
- R9: A pulse on `eng_done` sets status bit 16, which stays set until software clears it.
- R10: Writing a one to a status bit clears it at that edge, and writing a zero leaves it alone. A clear wins over a set at the same edge. A watermark flag cleared while its condition still holds sets again one edge later. Writing all ones clears every flag.
- R11: The enable register keeps bits 4, 12 and 16, and its other bits read zero. `irq` is high exactly when some flag is both pending and enabled.
- R12: After reset both counts are zero, and the status, enables, flush requests and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Software push into transmit FIFO |
| tx_wr_data | input | 8 | Byte to push |
| rx_rd_en | input | 1 | Software pop from receive FIFO |
| rx_rd_data | output | 8 | Receive FIFO head, zero when empty |
| eng_tx_pop | input | 1 | Engine pop from transmit FIFO |
| eng_tx_data | output | 8 | Transmit FIFO head, zero when empty |
| eng_rx_push | input | 1 | Engine push into receive FIFO |
| eng_rx_data | input | 8 | Byte received by engine |
| eng_done | input | 1 | Transfer-complete strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data (bit 8 TX flush, bit 9 RX flush) |
| flush_pend | output | 2 | Self-clearing flush requests (bit 0 TX, bit 1 RX) |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 32 | Enable write data |
| ien_rdata | output | 32 | Enable register contents |
| sta_wr | input | 1 | Status write-one-to-clear strobe |
| sta_wdata | input | 32 | Bits to clear |
| sta_rdata | output | 32 | Pending flags |
| fifo_sta | output | 32 | Packed fill counts |
| irq | output | 1 | Interrupt request |

## Verification
The transmit FIFO is first filled past capacity with no pops, which separates dropped overflow pushes from accepted ones. It is then drained past empty, which shows whether a pop from an empty FIFO returns zero and whether the 16-entry watermark is crossed. The receive FIFO is pushed up to 50 entries to cross the 48-entry mark. A flag is cleared while its condition holds, and a single write carries a push and a pop together, which separates the order of clear against set and of push against pop. A long random mix of strobes, flushes and register writes then runs against a queue-based model that is compared on every cycle.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CNT_FIELD  = 7;
  localparam int unsigned RX_CNT_LSB = 0;
  localparam int unsigned TX_CNT_LSB = 16;
  localparam int unsigned FLG_RX_HI  = 4;
  localparam int unsigned FLG_TX_LO  = 12;
  localparam int unsigned FLG_DONE   = 16;
  localparam int unsigned CTL_TX_FL  = 8;
  localparam int unsigned CTL_RX_FL  = 9;
  localparam int unsigned N_FIFO     = 2;

  function automatic logic [REG_W-1:0] flag_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[FLG_RX_HI] = 1'b1;
    m[FLG_TX_LO] = 1'b1;
    m[FLG_DONE]  = 1'b1;
    return m;
  endfunction

  function automatic int unsigned hi_mark(int unsigned depth);
    return (depth * 3) / 4;
  endfunction

  function automatic int unsigned lo_mark(int unsigned depth);
    return depth / 4;
  endfunction
endpackage

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fifo_flush_ctl.sv
module fifo_flush_ctl
  import fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [REG_W-1:0]  ctrl_wdata,
  output logic [N_FIFO-1:0] flush_q
);
  localparam int unsigned FL_BIT [N_FIFO] = '{CTL_TX_FL, CTL_RX_FL};
  localparam logic [REG_W-1:0] CTL_MASK = (REG_W'(1) << CTL_TX_FL) | (REG_W'(1) << CTL_RX_FL);

  logic [REG_W-1:0] ctl_bits;
  assign ctl_bits = ctrl_wr ? (ctrl_wdata & CTL_MASK) : '0;

  for (genvar i = 0; i < N_FIFO; i++) begin : g_fl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_q[i] <= 1'b0;
      else        flush_q[i] <= ctl_bits[FL_BIT[i]];
    end
  end
endmodule

// File: rtl/fifo_irq_flags.sv
module fifo_irq_flags
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    rx_count,
  input  logic [CW-1:0]    tx_count,
  input  logic             done,
  input  logic             sta_wr,
  input  logic [REG_W-1:0] sta_wdata,
  input  logic             ien_wr,
  input  logic [REG_W-1:0] ien_wdata,
  output logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] sta_q,
  output logic [REG_W-1:0] ien_q,
  output logic             irq
);
  localparam logic [REG_W-1:0] MASK = flag_mask();
  localparam logic [CW-1:0] HI_C = CW'(hi_mark(DEPTH));
  localparam logic [CW-1:0] LO_C = CW'(lo_mark(DEPTH));

  always_comb begin
    set_vec = '0;
    set_vec[FLG_RX_HI] = (rx_count >= HI_C);
    set_vec[FLG_TX_LO] = (tx_count <= LO_C);
    set_vec[FLG_DONE]  = done;
  end

  assign clr_vec = sta_wr ? (sta_wdata & MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      ien_q <= '0;
    end else begin
      sta_q <= (sta_q | set_vec) & ~clr_vec & MASK;
      if (ien_wr) ien_q <= ien_wdata & MASK;
    end
  end

  assign irq = |(sta_q & ien_q);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_en,
  input  logic [BYTE_W-1:0] tx_wr_data,
  input  logic              rx_rd_en,
  output logic [BYTE_W-1:0] rx_rd_data,
  input  logic              eng_tx_pop,
  output logic [BYTE_W-1:0] eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [BYTE_W-1:0] eng_rx_data,
  input  logic              eng_done,
  input  logic              ctrl_wr,
  input  logic [REG_W-1:0]  ctrl_wdata,
  output logic [N_FIFO-1:0] flush_pend,
  input  logic              ien_wr,
  input  logic [REG_W-1:0]  ien_wdata,
  output logic [REG_W-1:0]  ien_rdata,
  input  logic              sta_wr,
  input  logic [REG_W-1:0]  sta_wdata,
  output logic [REG_W-1:0]  sta_rdata,
  output logic [REG_W-1:0]  fifo_sta,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_count, rx_count;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic tx_flush, rx_flush;
  logic [REG_W-1:0] set_vec, clr_vec;

  fifo_flush_ctl u_fl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .flush_q(flush_pend)
  );
  assign tx_flush = flush_pend[0];
  assign rx_flush = flush_pend[1];

  fifo_byte_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr_en), .push_data(tx_wr_data), .pop(eng_tx_pop),
    .head(eng_tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  fifo_byte_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_push), .push_data(eng_rx_data), .pop(rx_rd_en),
    .head(rx_rd_data), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  fifo_irq_flags #(.DEPTH(DEPTH)) u_flg (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .done(eng_done), .sta_wr(sta_wr), .sta_wdata(sta_wdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .sta_q(sta_rdata), .ien_q(ien_rdata), .irq(irq)
  );

  always_comb begin
    fifo_sta = '0;
    fifo_sta[RX_CNT_LSB +: CNT_FIELD] = CNT_FIELD'(rx_count);
    fifo_sta[TX_CNT_LSB +: CNT_FIELD] = CNT_FIELD'(tx_count);
  end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_wr_en,
  input logic              eng_tx_pop,
  input logic              rx_rd_en,
  input logic              eng_rx_push,
  input logic              eng_done,
  input logic              ctrl_wr,
  input logic [REG_W-1:0]  ctrl_wdata,
  input logic [N_FIFO-1:0] flush_pend,
  input logic              sta_wr,
  input logic [REG_W-1:0]  sta_wdata,
  input logic [REG_W-1:0]  sta_rdata,
  input logic [REG_W-1:0]  fifo_sta,
  input logic              irq,
  input logic              tx_full,
  input logic              rx_empty
);
  localparam logic [CNT_FIELD-1:0] DEP_C = CNT_FIELD'(DEPTH);
  localparam logic [CNT_FIELD-1:0] HI_C  = CNT_FIELD'(hi_mark(DEPTH));

  logic [CNT_FIELD-1:0] txc, rxc;
  assign txc = fifo_sta[TX_CNT_LSB +: CNT_FIELD];
  assign rxc = fifo_sta[RX_CNT_LSB +: CNT_FIELD];

  assert_tx_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txc <= DEP_C);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr_en && !eng_tx_pop && !flush_pend[0]) |=> $stable(txc));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_rd_en && !eng_rx_push && !flush_pend[1]) |=> (rxc == '0));

  assert_flush_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend[0] && !(ctrl_wr && ctrl_wdata[CTL_TX_FL])) |=> !flush_pend[0]);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend[1] |=> (rxc == '0));

  assert_rx_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rxc >= HI_C) && !(sta_wr && sta_wdata[FLG_RX_HI])) |=> sta_rdata[FLG_RX_HI]);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !(sta_wr && sta_wdata[FLG_DONE])) |=> sta_rdata[FLG_DONE]);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_wr && sta_wdata[FLG_RX_HI]) |=> !sta_rdata[FLG_RX_HI]);

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_wr && (&sta_wdata)) |=> !irq);
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .eng_tx_pop(eng_tx_pop),
  .rx_rd_en(rx_rd_en), .eng_rx_push(eng_rx_push), .eng_done(eng_done),
  .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .flush_pend(flush_pend),
  .sta_wr(sta_wr), .sta_wdata(sta_wdata), .sta_rdata(sta_rdata),
  .fifo_sta(fifo_sta), .irq(irq), .tx_full(tx_full), .rx_empty(rx_empty)
);

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr_en = 0, rx_rd_en = 0, eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
  logic ctrl_wr = 0, ien_wr = 0, sta_wr = 0;
  logic [7:0] tx_wr_data = 0, eng_rx_data = 0;
  logic [31:0] ctrl_wdata = 0, ien_wdata = 0, sta_wdata = 0;
  logic [7:0] rx_rd_data, eng_tx_data;
  logic [1:0] flush_pend;
  logic [31:0] ien_rdata, sta_rdata, fifo_sta;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  spi_fifo_irq u0 (.*);

  // reference model
  localparam logic [31:0] FMASK = 32'h0001_1010;
  logic [7:0] mtx[$];
  logic [7:0] mrx[$];
  logic [31:0] msta = 0, mien = 0;
  logic mtxf = 0, mrxf = 0;

  always @(posedge clk) begin
    logic [31:0] setv;
    logic [31:0] clrv;
    bit tfull, rfull;
    if (!rst_n) begin
      mtx.delete(); mrx.delete();
      msta = 0; mien = 0; mtxf = 0; mrxf = 0;
    end else begin
      started = 1;
      setv = 0;
      if (mrx.size() >= 48) setv[4] = 1;
      if (mtx.size() <= 16) setv[12] = 1;
      if (eng_done) setv[16] = 1;
      clrv = sta_wr ? sta_wdata : 32'h0;
      msta = (msta | setv) & ~clrv & FMASK;
      if (ien_wr) mien = ien_wdata & FMASK;
      tfull = (mtx.size() == 64);
      rfull = (mrx.size() == 64);
      if (mtxf) mtx.delete();
      else begin
        if (eng_tx_pop && mtx.size() > 0) void'(mtx.pop_front());
        if (tx_wr_en && !tfull) mtx.push_back(tx_wr_data);
      end
      if (mrxf) mrx.delete();
      else begin
        if (rx_rd_en && mrx.size() > 0) void'(mrx.pop_front());
        if (eng_rx_push && !rfull) mrx.push_back(eng_rx_data);
      end
      mtxf = ctrl_wr && ctrl_wdata[8];
      mrxf = ctrl_wr && ctrl_wdata[9];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] est;
    logic [7:0] th, rh;
    if (rst_n && started && !ended) begin
      est = 0;
      est[6:0] = 7'(mrx.size());
      est[22:16] = 7'(mtx.size());
      th = (mtx.size() > 0) ? mtx[0] : 8'h00;
      rh = (mrx.size() > 0) ? mrx[0] : 8'h00;
      chk(fifo_sta == est, "R2 fifo_sta", fifo_sta, est);
      chk(eng_tx_data == th && rx_rd_data == rh, "R1 heads",
          {16'h0, eng_tx_data, rx_rd_data}, {16'h0, th, rh});
      chk(sta_rdata == msta, "R10 status", sta_rdata, msta);
      chk(ien_rdata == mien && irq == |(msta & mien), "R11 enable/irq",
          {ien_rdata[30:0], irq}, {mien[30:0], |(msta & mien)});
      chk(flush_pend == {mrxf, mtxf}, "R6 flush_pend",
          {30'h0, flush_pend}, {30'h0, mrxf, mtxf});
    end
  end

  task automatic step();
    @(negedge clk);
    tx_wr_en = 0; rx_rd_en = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_done = 0;
    ctrl_wr = 0; ien_wr = 0; sta_wr = 0;
  endtask

  task automatic summary();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(fifo_sta == 0 && sta_rdata == 0 && ien_rdata == 0 && !irq && flush_pend == 0,
        "R12 reset", {sta_rdata[30:0], irq}, 32'h0);
    rst_n = 1;
    step();
    chk(sta_rdata[12] == 1'b1, "R8 tx low after reset", sta_rdata, 32'h1000);
    // R3 overflow TX
    for (int i = 0; i < 70; i++) begin
      tx_wr_en = 1; tx_wr_data = 8'(i * 7 + 3); step();
    end
    chk(fifo_sta[22:16] == 64, "R3 tx full count", fifo_sta, 32'h0040_0000);
    // R10 clear bit 12 while count high: stays clear
    sta_wr = 1; sta_wdata = 32'h1000; step(); step();
    chk(sta_rdata[12] == 0, "R10 cleared stays clear", sta_rdata, 0);
    // R1/R8 drain to 16
    for (int i = 0; i < 48; i++) begin eng_tx_pop = 1; step(); end
    chk(eng_tx_data == 8'(48 * 7 + 3), "R1 order", eng_tx_data, 8'(48 * 7 + 3));
    step();
    chk(sta_rdata[12] == 1, "R8 tx at 16", sta_rdata, 32'h1000);
    // R4 drain past empty
    for (int i = 0; i < 20; i++) begin eng_tx_pop = 1; step(); end
    chk(fifo_sta[22:16] == 0 && eng_tx_data == 0, "R4 empty pop", fifo_sta, 0);
    // R7 rx fill
    ien_wr = 1; ien_wdata = 32'h0000_0010; step();
    for (int i = 0; i < 50; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'(255 - i); step();
    end
    step();
    chk(sta_rdata[4] == 1 && irq, "R7 rx mark", sta_rdata, 32'h10);
    // R10 clear while condition holds: clear then set again
    sta_wr = 1; sta_wdata = 32'h10; step();
    chk(sta_rdata[4] == 0, "R10 clear wins", sta_rdata, 0);
    step();
    chk(sta_rdata[4] == 1, "R10 re-set", sta_rdata, 32'h10);
    // R5 push+pop together
    eng_rx_push = 1; eng_rx_data = 8'h5a; rx_rd_en = 1; step();
    chk(fifo_sta[6:0] == 50 && rx_rd_data == 8'd254, "R5 push pop", fifo_sta, 50);
    // R6 flush rx, tx untouched
    tx_wr_en = 1; tx_wr_data = 8'h77; step();
    ctrl_wr = 1; ctrl_wdata = 32'h200; step();
    chk(flush_pend == 2'b10, "R6 pending", {30'h0, flush_pend}, 32'h2);
    step();
    chk(flush_pend == 0 && fifo_sta[6:0] == 0 && fifo_sta[22:16] == 1, "R6 flushed", fifo_sta, 32'h10000);
    // R9 done
    eng_done = 1; step(); step();
    chk(sta_rdata[16] == 1, "R9 done sticky", sta_rdata, 32'h10000);
    // R11 enables mask
    ien_wr = 1; ien_wdata = 32'hffff_ffff; step();
    chk(ien_rdata == FMASK && irq, "R11 mask", ien_rdata, FMASK);
    sta_wr = 1; sta_wdata = 32'hffff_ffff; step();
    chk(sta_rdata == 0 && !irq, "R10 clear all", sta_rdata, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      tx_wr_en = ($urandom_range(0, 99) < 55);
      tx_wr_data = 8'($urandom);
      eng_tx_pop = ($urandom_range(0, 99) < 45);
      eng_rx_push = ($urandom_range(0, 99) < 55);
      eng_rx_data = 8'($urandom);
      rx_rd_en = ($urandom_range(0, 99) < 45);
      eng_done = ($urandom_range(0, 99) < 3);
      ctrl_wr = ($urandom_range(0, 199) < 2);
      ctrl_wdata = $urandom;
      ien_wr = ($urandom_range(0, 99) < 3);
      ien_wdata = $urandom;
      sta_wr = ($urandom_range(0, 99) < 5);
      sta_wdata = $urandom;
      step();
    end
    step();
    summary();
  end
endmodule